// File: doc/BRIEF.md
# Exception Stack Frame Builder and Unwinder

This block writes an exception stack frame onto the supervisor stack when an exception is taken, and reads one back when the handler returns. It has three compatibility settings. The first is a plain mode with short frames. The second is a mode whose frames carry a format/vector-offset word. The third adds a six-word frame that holds the instruction address and can be switched on by an option. The frame's length and contents depend on the mode and on whether the exception is a bus or address error. On return, the frame format word decides how far the stack is unwound. It also decides whether the frame is rejected with a format error.

Stack traffic goes through a single valid/ready request channel with one 16-bit word per transfer. A request is either a write (a push) or a read (a pop). When `mem_valid` is high and `mem_ready` is low, the request is stalled. During a stall, address, write data and direction stay frozen, and nothing moves until the cycle in which both are high. Read data must be presented combinationally in the accepting cycle. A build or return starts with a one-cycle strobe while the block is idle. It ends with a one-cycle `done` pulse.

Mode encoding on `cpu_mode`: 0 is the plain mode, 1 is the format-word mode, and 2 or 3 is the extended mode.

Top module: `excframe_engine`

## Requirements
- R1: In mode 0, an ordinary exception (`fault_kind`=0) leaves a 3-word frame. From the final stack pointer upward it holds SR, PC[31:16] and PC[15:0].
- R2: In mode 0, a bus/address error (`fault_kind`=1) leaves a 7-word frame. From low to high address it holds status word, fault address high, fault address low, instruction register, SR, PC high and PC low.
- R3: In modes 1–3, an ordinary exception without the six-word option (always in mode 1) leaves a 4-word frame: SR, PC high, PC low and the format word. The format word holds the format code in bits 15..12 (here 0) and the vector number times 4 in bits 11..0.
- R4: In modes 2–3 with `frame2_en`=1, an ordinary exception leaves a 6-word frame. It holds SR, PC high, PC low, the format word with code 2, and then the instruction address high and low.
- R5: In modes 1–3, a bus/address error leaves a 29-word frame. It holds SR, PC high, PC low, the format word with code 8, status word, fault address high, fault address low and instruction register, followed by 21 zero words. `frame2_en` has no effect on it.
- R6: Each push decrements the stack pointer by 2 and writes at the new value, so words are written from the highest address to the lowest. After a build, `sp_out` equals `sp_in` minus twice the frame length.
- R7: A return in mode 0 reads only 3 words (SR, PC high, PC low), adds 6 to the stack pointer and never flags a format error, whatever the stored words hold.
- R8: A return in modes 1–3 reads 4 words. Code 0 unwinds 8 bytes and code 8 unwinds 58 bytes. Code 2 unwinds 12 bytes, but only in modes 2–3. Any other code raises `fmt_err` and leaves `sp_out` equal to `sp_in`. No write is issued during a return.
- R9: While `mem_valid` is high and `mem_ready` is low, the request stays up with unchanged address, data and direction. `mem_valid` is low whenever the block is idle.
- R10: `done` is a one-cycle pulse after which the block is idle. With `mem_ready` held high it comes N+1 cycles after the start strobe for an N-word build, 4 cycles after a mode-0 return and 5 cycles after any other return. Start strobes arriving while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| build_start | input | 1 | Start building a frame (idle only, wins over return) |
| return_start | input | 1 | Start unwinding a frame (idle only) |
| cpu_mode | input | 2 | Compatibility mode: 0 plain, 1 format word, 2/3 extended |
| frame2_en | input | 1 | Allow the six-word frame in extended mode |
| fault_kind | input | 1 | 1 = bus or address error, 0 = any other exception |
| vec_num | input | 8 | Exception vector number |
| sr_in | input | 16 | Status register to save |
| pc_in | input | 32 | Program counter to save |
| iaddr_in | input | 32 | Instruction address for the six-word frame |
| ssw_in | input | 16 | Internal status word for error frames |
| fault_addr_in | input | 32 | Faulting address for error frames |
| ir_in | input | 16 | Instruction register for error frames |
| sp_in | input | AW | Stack pointer at start |
| mem_valid | output | 1 | Stack word request valid |
| mem_ready | input | 1 | Stack memory accepts the request |
| mem_we | output | 1 | 1 = write (push), 0 = read (pop) |
| mem_addr | output | AW | Byte address of the stack word |
| mem_wdata | output | 16 | Word to push |
| mem_rdata | input | 16 | Word popped, valid in the accepting cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fmt_err | output | 1 | Last return rejected the frame format |
| sr_out | output | 16 | Restored status register |
| pc_out | output | 32 | Restored program counter |
| sp_out | output | AW | Current stack pointer |

## Verification
With ready held high, a build ends with `done` exactly one cycle after its last push. A mode-0 return ends on cycle 4 and any other return on cycle 5. The bench counts falling edges from the strobe and compares the count with these figures. Stack pointer, restored SR/PC and `fmt_err` are registered, so they are sampled on the falling edge where `done` is seen. Frame words are read from the bench memory after that point. In the stalled sweeps, timing is left unchecked, but the same end-state checks are made.

// File: rtl/excf_pkg.sv
package excf_pkg;
  localparam int IDXW = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_POP, ST_FIN} excf_state_e;

  localparam logic [3:0] FMT_SHORT  = 4'h0;
  localparam logic [3:0] FMT_LONGIA = 4'h2;
  localparam logic [3:0] FMT_BUSERR = 4'h8;

  typedef struct packed {
    logic [15:0] sr;
    logic [31:0] pc;
    logic [31:0] ia;
    logic [15:0] ssw;
    logic [31:0] fa;
    logic [15:0] ir;
    logic [7:0]  vec;
  } excf_fields_t;

  function automatic logic [IDXW-1:0] frame_len(logic [1:0] mode, logic berr, logic f2);
    if (mode == 2'd0) return berr ? IDXW'(7) : IDXW'(3);
    if (berr)         return IDXW'(29);
    if (mode[1] && f2) return IDXW'(6);
    return IDXW'(4);
  endfunction
endpackage

// File: rtl/excf_layout.sv
module excf_layout
  import excf_pkg::*;
(
  input  logic [1:0]      mode,
  input  logic            berr,
  input  logic            f2,
  input  excf_fields_t    fld,
  input  logic [IDXW-1:0] idx,
  output logic [15:0]     word
);
  logic [3:0]  fmt;
  logic [15:0] fvo;

  always_comb begin
    if (berr)                fmt = FMT_BUSERR;
    else if (mode[1] && f2)  fmt = FMT_LONGIA;
    else                     fmt = FMT_SHORT;
  end

  assign fvo = {fmt, 2'b00, fld.vec, 2'b00};

  always_comb begin
    word = 16'h0000;
    if (mode == 2'd0) begin
      if (berr) begin
        case (idx)
          5'd0: word = fld.ssw;
          5'd1: word = fld.fa[31:16];
          5'd2: word = fld.fa[15:0];
          5'd3: word = fld.ir;
          5'd4: word = fld.sr;
          5'd5: word = fld.pc[31:16];
          5'd6: word = fld.pc[15:0];
          default: word = 16'h0000;
        endcase
      end else begin
        case (idx)
          5'd0: word = fld.sr;
          5'd1: word = fld.pc[31:16];
          5'd2: word = fld.pc[15:0];
          default: word = 16'h0000;
        endcase
      end
    end else begin
      case (idx)
        5'd0: word = fld.sr;
        5'd1: word = fld.pc[31:16];
        5'd2: word = fld.pc[15:0];
        5'd3: word = fvo;
        5'd4: word = (fmt == FMT_BUSERR) ? fld.ssw : ((fmt == FMT_LONGIA) ? fld.ia[31:16] : 16'h0000);
        5'd5: word = (fmt == FMT_BUSERR) ? fld.fa[31:16] : ((fmt == FMT_LONGIA) ? fld.ia[15:0] : 16'h0000);
        5'd6: word = (fmt == FMT_BUSERR) ? fld.fa[15:0] : 16'h0000;
        5'd7: word = (fmt == FMT_BUSERR) ? fld.ir : 16'h0000;
        default: word = 16'h0000;
      endcase
    end
  end
endmodule

// File: rtl/excf_fmt_check.sv
module excf_fmt_check
  import excf_pkg::*;
(
  input  logic            ext_mode,
  input  logic [3:0]      fmt_code,
  output logic            accept,
  output logic [IDXW-1:0] skip_words
);
  always_comb begin
    accept     = 1'b0;
    skip_words = '0;
    case (fmt_code)
      FMT_SHORT:  begin accept = 1'b1;     skip_words = IDXW'(0);  end
      FMT_LONGIA: begin accept = ext_mode; skip_words = IDXW'(2);  end
      FMT_BUSERR: begin accept = 1'b1;     skip_words = IDXW'(25); end
      default:    begin accept = 1'b0;     skip_words = '0;        end
    endcase
  end
endmodule

// File: rtl/excframe_engine.sv
module excframe_engine
  import excf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          build_start,
  input  logic          return_start,
  input  logic [1:0]    cpu_mode,
  input  logic          frame2_en,
  input  logic          fault_kind,
  input  logic [7:0]    vec_num,
  input  logic [15:0]   sr_in,
  input  logic [31:0]   pc_in,
  input  logic [31:0]   iaddr_in,
  input  logic [15:0]   ssw_in,
  input  logic [31:0]   fault_addr_in,
  input  logic [15:0]   ir_in,
  input  logic [AW-1:0] sp_in,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fmt_err,
  output logic [15:0]   sr_out,
  output logic [31:0]   pc_out,
  output logic [AW-1:0] sp_out
);
  localparam logic [AW-1:0] WSTEP = AW'(2);

  excf_state_e     st_q;
  excf_fields_t    fld_q;
  logic [1:0]      mode_q;
  logic            berr_q, f2_q, err_q;
  logic [IDXW-1:0] idx_q;
  logic [AW-1:0]   sp_q, sp0_q;
  logic [15:0]     sr_q;
  logic [31:0]     pc_q;

  logic [15:0]     push_word;
  logic            fmt_ok;
  logic [IDXW-1:0] fmt_skip;
  logic            xfer;

  excf_layout u_layout (
    .mode (mode_q),
    .berr (berr_q),
    .f2   (f2_q),
    .fld  (fld_q),
    .idx  (idx_q),
    .word (push_word)
  );

  excf_fmt_check u_fmt (
    .ext_mode   (mode_q[1]),
    .fmt_code   (mem_rdata[15:12]),
    .accept     (fmt_ok),
    .skip_words (fmt_skip)
  );

  assign mem_valid = (st_q == ST_PUSH) || (st_q == ST_POP);
  assign mem_we    = (st_q == ST_PUSH);
  assign mem_addr  = (st_q == ST_PUSH) ? (sp_q - WSTEP) : sp_q;
  assign mem_wdata = push_word;
  assign xfer      = mem_valid && mem_ready;
  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign fmt_err   = err_q;
  assign sr_out    = sr_q;
  assign pc_out    = pc_q;
  assign sp_out    = sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fld_q  <= '0;
      mode_q <= 2'd0;
      berr_q <= 1'b0;
      f2_q   <= 1'b0;
      err_q  <= 1'b0;
      idx_q  <= '0;
      sp_q   <= '0;
      sp0_q  <= '0;
      sr_q   <= '0;
      pc_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (build_start) begin
            fld_q  <= '{sr: sr_in, pc: pc_in, ia: iaddr_in, ssw: ssw_in,
                        fa: fault_addr_in, ir: ir_in, vec: vec_num};
            mode_q <= cpu_mode;
            berr_q <= fault_kind;
            f2_q   <= frame2_en;
            idx_q  <= frame_len(cpu_mode, fault_kind, frame2_en) - IDXW'(1);
            sp_q   <= sp_in;
            err_q  <= 1'b0;
            st_q   <= ST_PUSH;
          end else if (return_start) begin
            mode_q <= cpu_mode;
            idx_q  <= '0;
            sp_q   <= sp_in;
            sp0_q  <= sp_in;
            err_q  <= 1'b0;
            st_q   <= ST_POP;
          end
        end
        ST_PUSH: begin
          if (xfer) begin
            sp_q <= sp_q - WSTEP;
            if (idx_q == '0) st_q <= ST_FIN;
            else             idx_q <= idx_q - IDXW'(1);
          end
        end
        ST_POP: begin
          if (xfer) begin
            case (idx_q)
              IDXW'(0): sr_q         <= mem_rdata;
              IDXW'(1): pc_q[31:16]  <= mem_rdata;
              IDXW'(2): pc_q[15:0]   <= mem_rdata;
              default: ;
            endcase
            if (mode_q == 2'd0 && idx_q == IDXW'(2)) begin
              sp_q <= sp_q + WSTEP;
              st_q <= ST_FIN;
            end else if (idx_q == IDXW'(3)) begin
              if (fmt_ok) begin
                sp_q <= sp_q + WSTEP + AW'({fmt_skip, 1'b0});
              end else begin
                sp_q  <= sp0_q;
                err_q <= 1'b1;
              end
              st_q <= ST_FIN;
            end else begin
              sp_q  <= sp_q + WSTEP;
              idx_q <= idx_q + IDXW'(1);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/excframe_engine_chk.sv
module excframe_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          build_start,
  input logic          return_start,
  input logic          busy,
  input logic          done,
  input logic          fmt_err,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_wdata,
  input logic [AW-1:0] sp_out
);
  logic in_ret;

  always_ff @(posedge clk) begin
    if (!rst_n)                    in_ret <= 1'b0;
    else if (!busy && build_start) in_ret <= 1'b0;
    else if (!busy && return_start) in_ret <= 1'b1;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid); // R9

  AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && mem_we |=> sp_out == $past(sp_out) - AW'(2)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R10

  AST_RET_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && in_ret |-> !mem_we); // R8

  AST_ERR_FROM_RET: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_err |-> in_ret); // R8
endmodule

bind excframe_engine excframe_engine_chk #(.AW(AW)) chk_i (.*);

// File: tb/excframe_engine_tb_top.sv
module excframe_engine_tb_top;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk; // 20-unit period: 50 MHz

  logic          build_start = 0, return_start = 0, frame2_en = 0, fault_kind = 0;
  logic [1:0]    cpu_mode = 0;
  logic [7:0]    vec_num = 0;
  logic [15:0]   sr_in = 0, ssw_in = 0, ir_in = 0;
  logic [31:0]   pc_in = 0, iaddr_in = 0, fault_addr_in = 0;
  logic [AW-1:0] sp_in = 0;
  logic          mem_valid, mem_ready, mem_we, busy, done, fmt_err;
  logic [AW-1:0] mem_addr, sp_out;
  logic [15:0]   mem_wdata, mem_rdata, sr_out;
  logic [31:0]   pc_out;

  logic [15:0] mem [0:127];
  logic        tb_we = 0;
  logic [6:0]  tb_a = 0;
  logic [15:0] tb_d = 0;
  logic        stall = 0;
  logic [7:0]  lf;

  int n_chk = 0, n_fail = 0;

  excframe_engine #(.AW(AW)) dut_i (.*);

  assign mem_ready = stall ? lf[0] : 1'b1;
  assign mem_rdata = mem[mem_addr[7:1]];

  always @(posedge clk) begin
    if (!rst_n) lf <= 8'h5A;
    else        lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    if (mem_valid && mem_ready && mem_we) mem[mem_addr[7:1]] <= mem_wdata;
    if (tb_we) mem[tb_a] <= tb_d;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    @(negedge clk); tb_we = 1; tb_a = 7'(a); tb_d = d;
    @(negedge clk); tb_we = 0;
  endtask

  function automatic int exp_len(int m, int k, int f2);
    if (m == 0) return k ? 7 : 3;
    if (k) return 29;
    if (m >= 2 && f2) return 6;
    return 4;
  endfunction

  function automatic logic [15:0] exp_word(int m, int k, int f2, int j);
    logic [3:0] f;
    if (m == 0) begin
      if (k) begin
        case (j)
          0: return ssw_in;  1: return fault_addr_in[31:16]; 2: return fault_addr_in[15:0];
          3: return ir_in;   4: return sr_in; 5: return pc_in[31:16]; default: return pc_in[15:0];
        endcase
      end
      case (j) 0: return sr_in; 1: return pc_in[31:16]; default: return pc_in[15:0]; endcase
    end
    f = k ? 4'h8 : ((m >= 2 && f2) ? 4'h2 : 4'h0);
    case (j)
      0: return sr_in;
      1: return pc_in[31:16];
      2: return pc_in[15:0];
      3: return {f, 2'b00, vec_num, 2'b00};
      default: ;
    endcase
    if (f == 4'h2) return (j == 4) ? iaddr_in[31:16] : iaddr_in[15:0];
    if (f == 4'h8) begin
      case (j)
        4: return ssw_in; 5: return fault_addr_in[31:16];
        6: return fault_addr_in[15:0]; 7: return ir_in; default: return 16'h0000;
      endcase
    end
    return 16'h0000;
  endfunction

  // Returns cycle count from strobe to done, or -1 on timeout.
  task automatic run_op(input bit is_build, input bit poke_busy, output int cyc);
    @(negedge clk);
    if (is_build) build_start = 1; else return_start = 1;
    cyc = 0;
    forever begin
      @(negedge clk);
      build_start = 0; return_start = 0;
      cyc++;
      if (poke_busy && cyc == 2) begin build_start = 1; return_start = 1; end
      if (done) break;
      if (cyc > 2000) begin cyc = -1; break; end
    end
    build_start = 0; return_start = 0;
  endtask

  task automatic do_build(input int m, input int k, input int f2, input bit st, input int n, input bit poke_busy);
    int len, cyc, base;
    string tag;
    for (int i = 0; i < 128; i++) begin mem[i] = 16'hDEAD; end
    cpu_mode = 2'(m); fault_kind = k[0]; frame2_en = f2[0]; stall = st;
    vec_num = 8'(8'h40 + n); sr_in = 16'(16'h2700 + n);
    pc_in = 32'h0012_3456 + 32'(n * 32'h0101_0000); iaddr_in = 32'h00AB_CDE0 + 32'(n);
    ssw_in = 16'(16'h0100 + n); fault_addr_in = 32'h7700_1000 + 32'(n); ir_in = 16'(16'h4E70 + n);
    sp_in = 32'hF0;
    len = exp_len(m, k, f2);
    tag = (m == 0) ? (k ? "R2" : "R1") : (k ? "R5" : ((m >= 2 && f2) ? "R4" : "R3"));
    run_op(1'b1, poke_busy, cyc);
    chk(cyc >= 0, "R10 build timeout", cyc, len + 1);
    if (!st) chk(cyc == len + 1, "R10 build latency", cyc, len + 1);
    chk(sp_out == 32'(32'hF0 - 2 * len), "R6 final sp", sp_out, 32'hF0 - 2 * len);
    chk(fmt_err == 1'b0, "R8 no err after build", fmt_err, 0);
    base = (32'hF0 - 2 * len) / 2;
    for (int j = 0; j < len; j++) begin
      chk(mem[base + j] == exp_word(m, k, f2, j), tag, mem[base + j], exp_word(m, k, f2, j));
    end
    chk(mem[base - 1] == 16'hDEAD, "R6 below frame untouched", mem[base - 1], 16'hDEAD);
    chk(mem[120] == 16'hDEAD, "R6 above frame untouched", mem[120], 16'hDEAD);
  endtask

  task automatic do_ret(input int m, input int f, input bit st);
    int cyc, exp_sp, exp_cyc;
    bit ok;
    cpu_mode = 2'(m); stall = st; sp_in = 32'hC0;
    poke(32'hC0 / 2, 16'(16'h2000 + f));
    poke(32'hC0 / 2 + 1, 16'(16'hABC0 + m));
    poke(32'hC0 / 2 + 2, 16'h1234);
    poke(32'hC0 / 2 + 3, {4'(f), 12'h1FC});
    if (m == 0)                 begin ok = 1; exp_sp = 32'hC6; end
    else if (f == 0)            begin ok = 1; exp_sp = 32'hC8; end
    else if (f == 8)            begin ok = 1; exp_sp = 32'hC0 + 58; end
    else if (f == 2 && m >= 2)  begin ok = 1; exp_sp = 32'hCC; end
    else                        begin ok = 0; exp_sp = 32'hC0; end
    exp_cyc = (m == 0) ? 4 : 5;
    run_op(1'b0, 1'b0, cyc);
    chk(cyc >= 0, "R10 return timeout", cyc, exp_cyc);
    if (!st) chk(cyc == exp_cyc, "R10 return latency", cyc, exp_cyc);
    if (m == 0) chk(fmt_err == 1'b0, "R7 no format error", fmt_err, 0);
    else        chk(fmt_err == !ok, "R8 format accept", fmt_err, !ok);
    chk(sp_out == exp_sp, (m == 0) ? "R7 sp unwind" : "R8 sp unwind", sp_out, exp_sp);
    if (ok) begin
      chk(sr_out == 16'(16'h2000 + f), "R7 R8 sr restore", sr_out, 16'h2000 + f);
      chk(pc_out == {16'(16'hABC0 + m), 16'h1234}, "R7 R8 pc restore", pc_out, {16'(16'hABC0 + m), 16'h1234});
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0, "R10 reset busy", busy, 0);
    chk(done == 0, "R10 reset done", done, 0);
    chk(mem_valid == 0, "R9 reset valid", mem_valid, 0);
    chk(fmt_err == 0, "R8 reset fmt_err", fmt_err, 0);
    n = 0;
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 2; k++)
        for (int f2 = 0; f2 < 2; f2++)
          for (int st = 0; st < 2; st++) begin
            do_build(m, k, f2, st[0], n, 1'b0);
            n++;
          end
    // Start strobes while busy must not disturb the frame in progress (R10)
    do_build(1, 0, 0, 1'b0, 7, 1'b1);
    for (int m = 0; m < 4; m++)
      for (int f = 0; f < 16; f++)
        do_ret(m, f, f[0]);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule